// File: doc/BRIEF.md
# ADC Scan Sequencer

This block decides which analog channel a successive-approximation converter samples next, and when. Software programs an eight-slot channel list, a run mode and a conversion length, then raises the start bit. The sequencer pulses a start strobe to the converter, holds the channel select steady for the programmed number of clocks, captures the returned sample, and writes it to the result bank, tagged with the slot it belongs to.

There are three run modes: one conversion of slot 0, one pass through all eight slots, and endless scanning. Enabling the down-sample path forces endless scanning whatever the mode field holds. In the two one-shot modes the start bit clears itself when the work is done. In endless scanning it stays set until software clears it, and that clear also abandons any conversion in flight. The end-of-conversion flag and its interrupt mark a finished single conversion or a finished pass. The busy output and the current-channel output give software a view of the sequencer's progress.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, busy, eoc_flag, irq, conv_start and res_we are all 0.
- R2: Slot k takes its 4-bit channel from seq_word[4k+3:4k]. Slots are converted in ascending order, 0 first and 7 last. While slot k is converting, conv_chan and cur_chan carry its channel. Its result is written with res_slot = k and res_data = the conv_data value present in the last cycle of the conversion.
- R3: Mode code 00 converts slot 0 once, then clears the start bit and sets eoc_flag. The reserved code 01 behaves the same way.
- R4: Mode code 10 converts slots 0 to 7 once each, then clears the start bit and sets eoc_flag.
- R5: Mode code 11 wraps from slot 7 back to slot 0 and sets eoc_flag at the end of every pass. It keeps converting until start_clr is pulsed.
- R6: While cfg_dsmp_en is 1, the sequencer scans continuously, as in R5, whatever cfg_mode holds.
- R7: A conversion lasts max(conv_clks, 11) cycles. This is the spacing from a conv_start pulse to its result write, and from one conv_start to the next within a scan.
- R8: eoc_flag stays set until eoc_clr is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R9: irq is 1 exactly when eoc_flag is 1 and cfg_irq_en is 1.
- R10: busy mirrors the start bit. start_set sets it, start_clr clears it, and start_clr wins when both arrive together.
- R11: While cfg_enable is 0, no conversion starts and no result is written, even if the start bit is set. A pending start begins once cfg_enable returns to 1.
- R12: A start_clr in mid-scan abandons the conversion in flight without writing it or setting eoc_flag. The next start begins again at slot 0.
- R13: conv_start is a single-cycle pulse, issued once per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Converter enable |
| cfg_mode | input | 2 | Run mode code |
| cfg_dsmp_en | input | 1 | Down-sample enable; forces continuous scanning |
| cfg_irq_en | input | 1 | Interrupt enable |
| seq_word | input | 32 | Eight 4-bit slot channel codes |
| conv_clks | input | 7 | Clocks per conversion (values below 11 act as 11) |
| start_set | input | 1 | Software writes 1 to the start bit |
| start_clr | input | 1 | Software writes 0 to the start bit |
| eoc_clr | input | 1 | Software writes 1 to clear eoc_flag |
| conv_data | input | 12 | Sample returned by the converter |
| conv_start | output | 1 | Start strobe to the converter |
| conv_chan | output | 4 | Channel select to the converter |
| res_we | output | 1 | Result bank write strobe |
| res_slot | output | 3 | Result bank slot index |
| res_data | output | 12 | Result bank write data |
| busy | output | 1 | Busy status, a mirror of the start bit |
| cur_chan | output | 4 | Channel currently being converted |
| eoc_flag | output | 1 | End-of-conversion flag |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
The hardest situation to reach from the ports is an abort in the middle of a single pass. It needs a start_clr that lands during a conversion, after some slots have already been written, and then a restart that must begin again at slot 0 without a stale eoc_flag. The stimulus counts result writes during a slot-pass run and pulses start_clr on the cycle the third write appears. At that moment the fourth conversion has just begun. The stimulus then restarts the pass and checks that the first write carries slot 0. A second hard case is a start bit held while the converter is disabled. The stimulus reaches it by setting the start bit with cfg_enable low, checking for tens of cycles that no conversion starts, and then raising cfg_enable.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      MODE_ONE  = 2'b00,
      MODE_RSV  = 2'b01,
      MODE_PASS = 2'b10,
      MODE_LOOP = 2'b11
   } run_mode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_CONV = 1'b1
   } seq_state_e;

endpackage

// File: rtl/adc_seq_chan_pick.sv
module adc_seq_chan_pick #(
   parameter int N_SLOTS = 8,
   parameter int CHAN_W  = 4,
   localparam int SLOT_W = $clog2(N_SLOTS)
) (
   input  logic [N_SLOTS*CHAN_W-1:0] seq_word,
   input  logic [SLOT_W-1:0]         slot,
   output logic [CHAN_W-1:0]         chan
);

   logic [CHAN_W-1:0] slot_chan [N_SLOTS];

   for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
      assign slot_chan[k] = seq_word[k*CHAN_W +: CHAN_W];
   end

   assign chan = slot_chan[slot];

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int CNT_W    = 7,
   parameter int MIN_CLKS = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [CNT_W-1:0] clks_cfg,
   output logic             last
);

   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CLKS);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_m1;

   assign len_m1 = (clks_cfg < MIN_V) ? (MIN_V - CNT_W'(1)) : (clks_cfg - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= '0;
      end else if (run && (cnt_q != len_m1)) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign last = run && (cnt_q == len_m1);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_seq_pkg::*;
#(
   parameter int N_SLOTS  = 8,
   parameter int CHAN_W   = 4,
   parameter int DATA_W   = 12,
   parameter int CNT_W    = 7,
   parameter int MIN_CLKS = 11,
   localparam int SLOT_W  = $clog2(N_SLOTS),
   localparam int SEQ_W   = N_SLOTS * CHAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_dsmp_en,
   input  logic              cfg_irq_en,
   input  logic [SEQ_W-1:0]  seq_word,
   input  logic [CNT_W-1:0]  conv_clks,
   input  logic              start_set,
   input  logic              start_clr,
   input  logic              eoc_clr,
   input  logic [DATA_W-1:0] conv_data,
   output logic              conv_start,
   output logic [CHAN_W-1:0] conv_chan,
   output logic              res_we,
   output logic [SLOT_W-1:0] res_slot,
   output logic [DATA_W-1:0] res_data,
   output logic              busy,
   output logic [CHAN_W-1:0] cur_chan,
   output logic              eoc_flag,
   output logic              irq
);

   // elaboration-time parameter checks
   if (N_SLOTS < 2 || (N_SLOTS & (N_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("N_SLOTS must be a power of two, at least 2");
   end
   if (MIN_CLKS < 2 || MIN_CLKS >= (1 << CNT_W)) begin : g_bad_min
      $error("MIN_CLKS must fit the conversion counter");
   end
   if (CHAN_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("CHAN_W and DATA_W must be positive");
   end

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

   seq_state_e        state_q;
   logic [SLOT_W-1:0] slot_q;
   logic              start_q;
   logic              eoc_q;
   logic              pulse_q;
   logic              we_q;
   logic [SLOT_W-1:0] we_slot_q;
   logic [DATA_W-1:0] we_data_q;

   run_mode_e eff_mode;
   logic      is_scan, is_loop, last_slot;
   logic      abort, finish, launch, cont, seq_done, tmr_last;

   // down-sample forces endless scanning; reserved code behaves as one-shot
   assign eff_mode  = cfg_dsmp_en ? MODE_LOOP : run_mode_e'(cfg_mode);
   assign is_scan   = (eff_mode == MODE_PASS) || (eff_mode == MODE_LOOP);
   assign is_loop   = (eff_mode == MODE_LOOP);
   assign last_slot = (slot_q == LAST_SLOT);

   assign abort    = (state_q == ST_CONV) && (start_clr || !cfg_enable);
   assign finish   = (state_q == ST_CONV) && tmr_last && !abort;
   assign launch   = (state_q == ST_IDLE) && start_q && cfg_enable && !start_clr;
   assign cont     = finish && is_scan && (is_loop || !last_slot);
   assign seq_done = finish && (!is_scan || last_slot);

   adc_seq_timer #(
      .CNT_W    (CNT_W),
      .MIN_CLKS (MIN_CLKS)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (launch || cont),
      .run      (state_q == ST_CONV),
      .clks_cfg (conv_clks),
      .last     (tmr_last)
   );

   adc_seq_chan_pick #(
      .N_SLOTS (N_SLOTS),
      .CHAN_W  (CHAN_W)
   ) i_pick (
      .seq_word (seq_word),
      .slot     (slot_q),
      .chan     (conv_chan)
   );

   // sequencer state and slot pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         slot_q  <= '0;
      end else if (abort) begin
         state_q <= ST_IDLE;
         slot_q  <= '0;
      end else if (launch) begin
         state_q <= ST_CONV;
      end else if (finish) begin
         if (cont) begin
            slot_q <= last_slot ? '0 : slot_q + SLOT_W'(1);
         end else begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
         end
      end
   end

   // software start bit with hardware self-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
      end else if (start_clr) begin
         start_q <= 1'b0;
      end else if (start_set) begin
         start_q <= 1'b1;
      end else if (finish && !cont) begin
         start_q <= 1'b0;
      end
   end

   // end-of-conversion flag: set wins over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_q <= 1'b0;
      end else if (seq_done) begin
         eoc_q <= 1'b1;
      end else if (eoc_clr) begin
         eoc_q <= 1'b0;
      end
   end

   // converter strobe and result bank write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q   <= 1'b0;
         we_q      <= 1'b0;
         we_slot_q <= '0;
         we_data_q <= '0;
      end else begin
         pulse_q <= launch || cont;
         we_q    <= finish;
         if (finish) begin
            we_slot_q <= slot_q;
            we_data_q <= conv_data;
         end
      end
   end

   assign conv_start = pulse_q;
   assign res_we     = we_q;
   assign res_slot   = we_slot_q;
   assign res_data   = we_data_q;
   assign busy       = start_q;
   assign cur_chan   = conv_chan;
   assign eoc_flag   = eoc_q;
   assign irq        = eoc_q && cfg_irq_en;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_enable,
   input logic start_clr,
   input logic eoc_clr,
   input logic conv_start,
   input logic res_we,
   input logic busy,
   input logic eoc_flag
);

   AST_START_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);                              // R10

   AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> !conv_start);                      // R11

   AST_CLR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      start_clr |=> !busy);                              // R10

   AST_EOC_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_flag) |-> res_we);                       // R8

   AST_EOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_clr |=> (!eoc_flag || res_we));                // R8

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);                       // R13

endmodule

bind adc_scan_seq adc_scan_seq_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_enable (cfg_enable),
   .start_clr  (start_clr),
   .eoc_clr    (eoc_clr),
   .conv_start (conv_start),
   .res_we     (res_we),
   .busy       (busy),
   .eoc_flag   (eoc_flag)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;

   typedef struct packed {
      logic [1:0]  mode;
      logic        dsmp;
      logic        irq_en;
      logic [6:0]  clks;
      logic [31:0] seq;
      logic [7:0]  len;
      logic [3:0]  writes;
      logic        autostop;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 1'b0, 1'b1, 7'd11,  32'h7654_3210, 8'd11,  4'd1,  1'b1},
      '{2'b10, 1'b0, 1'b0, 7'd5,   32'h0F1E_2D3C, 8'd11,  4'd8,  1'b1},
      '{2'b11, 1'b0, 1'b1, 7'd20,  32'h89AB_CDEF, 8'd20,  4'd10, 1'b0},
      '{2'b00, 1'b1, 1'b1, 7'd12,  32'h1357_9BDF, 8'd12,  4'd10, 1'b0},
      '{2'b01, 1'b0, 1'b0, 7'd127, 32'h0000_000C, 8'd127, 4'd1,  1'b1},
      '{2'b10, 1'b0, 1'b1, 7'd0,   32'hA5C3_9E71, 8'd11,  4'd8,  1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b1;
   logic [1:0]  cfg_mode = 2'b00;
   logic        cfg_dsmp_en = 1'b0;
   logic        cfg_irq_en = 1'b0;
   logic [31:0] seq_word = '0;
   logic [6:0]  conv_clks = 7'd11;
   logic        start_set = 1'b0;
   logic        start_clr = 1'b0;
   logic        eoc_clr = 1'b0;
   logic [11:0] conv_data;
   logic        conv_start, res_we, busy, eoc_flag, irq;
   logic [3:0]  conv_chan, cur_chan;
   logic [2:0]  res_slot;
   logic [11:0] res_data;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // converter stub: sample encodes the selected channel
   assign conv_data = {8'hC3, conv_chan};

   adc_scan_seq i_adc_scan_seq (
      .clk (clk), .rst_n (rst_n), .cfg_enable (cfg_enable), .cfg_mode (cfg_mode),
      .cfg_dsmp_en (cfg_dsmp_en), .cfg_irq_en (cfg_irq_en), .seq_word (seq_word),
      .conv_clks (conv_clks), .start_set (start_set), .start_clr (start_clr),
      .eoc_clr (eoc_clr), .conv_data (conv_data), .conv_start (conv_start),
      .conv_chan (conv_chan), .res_we (res_we), .res_slot (res_slot),
      .res_data (res_data), .busy (busy), .cur_chan (cur_chan),
      .eoc_flag (eoc_flag), .irq (irq)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); start_set = 1'b1;
      @(negedge clk); start_set = 1'b0;
   endtask

   task automatic clear_eoc();
      @(negedge clk); eoc_clr = 1'b1;
      @(negedge clk); eoc_clr = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      int    starts = 0, writes = 0, last_start = -1, guard = 0;
      bit    was_busy = 0, prev_cs = 0, one_shot;
      int    es, ws;
      string tag;
      one_shot = !v.mode[1] && !v.dsmp;
      tag = v.dsmp ? "R6" : (v.mode == 2'b11) ? "R5" : (v.mode == 2'b10) ? "R4" : "R3";
      @(negedge clk);
      cfg_mode = v.mode; cfg_dsmp_en = v.dsmp; cfg_irq_en = v.irq_en;
      conv_clks = v.clks; seq_word = v.seq;
      pulse_start();
      while (guard < 4000) begin
         if (guard > 0) @(negedge clk);
         guard++;
         start_clr = 1'b0;
         if (busy) was_busy = 1;
         if (res_we) begin
            ws = one_shot ? 0 : writes % 8;
            chk("R2", "result slot", int'(res_slot), ws);
            chk("R2", "result data", int'(res_data), int'({8'hC3, v.seq[ws*4 +: 4]}));
            chk("R7", "start to write", cyc - last_start, int'(v.len));
            writes++;
            if (!v.autostop && writes == int'(v.writes)) start_clr = 1'b1;
         end
         if (conv_start) begin
            es = one_shot ? 0 : starts % 8;
            chk("R13", "start pulse width", int'(prev_cs), 0);
            chk("R2", "channel select", int'(cur_chan), int'(v.seq[es*4 +: 4]));
            if (last_start >= 0) chk("R7", "start spacing", cyc - last_start, int'(v.len));
            last_start = cyc;
            starts++;
         end
         prev_cs = conv_start;
         if (was_busy && !busy) break;
      end
      chk(tag, "write count", writes, int'(v.writes));
      chk("R10", "busy after run", int'(busy), 0);
      chk("R8", "eoc after run", int'(eoc_flag), 1);
      chk("R9", "irq with eoc", int'(irq), int'(v.irq_en));
      clear_eoc();
      chk("R8", "eoc cleared", int'(eoc_flag), 0);
      chk("R9", "irq cleared", int'(irq), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int seen;
      int first_slot;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "eoc", int'(eoc_flag), 0);
      chk("R1", "irq", int'(irq), 0);
      chk("R1", "conv_start", int'(conv_start), 0);
      chk("R1", "res_we", int'(res_we), 0);

      // table of vectors
      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R10: clear wins over set
      @(negedge clk); start_set = 1'b1; start_clr = 1'b1;
      @(negedge clk); start_set = 1'b0; start_clr = 1'b0;
      chk("R10", "clear priority", int'(busy), 0);
      repeat (20) @(negedge clk);
      chk("R10", "no run after clear", int'(busy), 0);

      // R11: disabled converter holds a pending start
      cfg_mode = 2'b00; cfg_dsmp_en = 1'b0; conv_clks = 7'd11; seq_word = 32'h0000_0005;
      cfg_enable = 1'b0;
      pulse_start();
      seen = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (conv_start || res_we) seen++;
      end
      chk("R11", "activity while disabled", seen, 0);
      chk("R10", "busy mirrors start", int'(busy), 1);
      cfg_enable = 1'b1;
      seen = 0;
      for (int c = 0; c < 100 && seen == 0; c++) begin
         @(negedge clk);
         if (res_we) seen = 1;
      end
      chk("R11", "runs after enable", seen, 1);
      clear_eoc();

      // R12: abort in mid-pass, then restart from slot 0
      cfg_mode = 2'b10; seq_word = 32'h7654_3210;
      pulse_start();
      seen = 0;
      while (seen < 3) begin
         @(negedge clk);
         if (res_we) seen++;
      end
      start_clr = 1'b1;
      @(negedge clk); start_clr = 1'b0;
      seen = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (res_we || conv_start) seen++;
      end
      chk("R12", "activity after abort", seen, 0);
      chk("R12", "busy after abort", int'(busy), 0);
      chk("R12", "no eoc on abort", int'(eoc_flag), 0);
      pulse_start();
      first_slot = -1;
      for (int c = 0; c < 100 && first_slot < 0; c++) begin
         @(negedge clk);
         if (res_we) first_slot = int'(res_slot);
      end
      chk("R12", "restart slot", first_slot, 0);
      for (int c = 0; c < 200 && busy; c++) @(negedge clk);
      chk("R4", "restarted pass ends", int'(busy), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule